// File: doc/BRIEF.md
# Shared Memory Bank Conflict Checker

The checker takes the byte addresses that the 64 lanes of a wavefront present for one 128-bit shared-memory access. It works out how badly the banks collide. The memory model has 32 banks, each one 32-bit word wide. A lane's 16-byte access covers four consecutive banks. Hardware serves the lanes in eight phases of eight lanes, and only lanes in the same phase can collide. The phase membership depends on whether the access is a write or a read. Writes group runs of consecutive lanes. Reads group fixed pairs of four-lane runs.

For each phase the block reports a conflict degree: the largest number of distinct words that fall into one bank. It also reports the worst degree over all phases and a flag that is high when the whole access is free of conflicts. A swizzle mode replaces the raw addresses with a row and vector column per lane. The column is XOR-permuted with the low bits of the row before the address is formed. Software can therefore judge a swizzled layout directly. Results are pipelined, with a fixed latency of two cycles and one new request accepted per cycle. The block holds no memory storage.

Top module: `bank_conflict_chk`

## Requirements
- R1: A 32-bit word index is the byte address shifted right by 2, and its bank is the word index mod 32. A lane touches the four consecutive words starting at its own word index. The word index wraps within AW-2 bits, so the bank wraps from 31 back to 0.
- R2: With `in_read`=0, phase p (0..7) holds lanes 8p to 8p+7.
- R3: With `in_read`=1, phase p holds two runs of four lanes. Let h = 32·(p div 4) and q = p mod 4. The runs start at lanes h+4q and h+16+4·(q XOR 1).
- R4: The degree of a phase is the maximum, over the 32 banks, of the number of distinct word indices that the phase's lanes touch in that bank. Identical words count once, so the degree is between 1 and 8.
- R5: `out_max_deg` equals the largest of the eight phase degrees. `out_conf_free` is 1 exactly when every phase degree is at most 1.
- R6: The result of a request taken with `in_valid`=1 at a clock edge appears with `out_valid`=1 after the second following edge. Requests may arrive on every cycle, and `out_valid` is 0 two edges after a cycle without a request.
- R7: With `in_swz`=1, the lane address is BASE_ADDR + 2·(row·ROW_STRIDE + ((row mod 8) XOR col)·8), truncated to AW bits, and `in_addr` has no effect. With `in_swz`=0, `in_addr` is used and the row and column inputs have no effect. Lane l's fields sit at `in_addr[l*AW +: AW]`, `in_row[l*RW +: RW]` and `in_col[l*3 +: 3]`.
- R8: After reset, `out_valid`, `out_phase_deg`, `out_max_deg` and `out_conf_free` are all 0. Phase p's degree is at `out_phase_deg[4p +: 4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_read | input | 1 | 1 = read phase grouping, 0 = write grouping |
| in_swz | input | 1 | 1 = form addresses from row/column with XOR swizzle |
| in_addr | input | 64·AW | Per-lane byte address |
| in_row | input | 64·RW | Per-lane row index (swizzle mode) |
| in_col | input | 64·3 | Per-lane vector column (swizzle mode) |
| out_valid | output | 1 | Result strobe |
| out_phase_deg | output | 32 | Eight 4-bit phase degrees |
| out_max_deg | output | 4 | Worst phase degree |
| out_conf_free | output | 1 | All phases conflict free |

## Verification
Two cases are hard to reach from the ports. One is a phase in which lanes share an identical word while other lanes fall in the same bank with different words; only that case separates counting distinct words from counting lanes. The other is an access that is clean under one phase grouping but conflicts under the other. Random stimulus draws addresses from a narrow window, so duplicates and same-bank collisions occur often. Directed patterns with a 128-byte lane stride, half-offset lanes that wrap the bank index, and swizzled versus unswizzled row layouts pin the degree-8, wrap and swizzle corners, and the inputs that should have no effect carry random values.

// File: rtl/bank_conflict_chk.sv
module bank_conflict_chk #(
  parameter int AW         = 16,
  parameter int RW         = 8,
  parameter int ROW_STRIDE = 64,
  parameter int KPER_BLK   = 64,
  parameter int KPACK      = 8,
  parameter int BASE_ADDR  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_read,
  input  logic                  in_swz,
  input  logic [64*AW-1:0]      in_addr,
  input  logic [64*RW-1:0]      in_row,
  input  logic [64*3-1:0]       in_col,
  output logic                  out_valid,
  output logic [31:0]           out_phase_deg,
  output logic [3:0]            out_max_deg,
  output logic                  out_conf_free
);
  localparam int NLANE = 64;
  localparam int NPH   = 8;
  localparam int NSLOT = 32;
  localparam int NBANK = 32;
  localparam int NCOL  = KPER_BLK / KPACK;
  localparam int CW    = 3;
  localparam int WW    = AW - 2;
  localparam int DW    = 4;

  function automatic int lane_of(int p, int i, logic rd);
    int h, q;
    h = (p / 4) * 32;
    q = p % 4;
    if (!rd) return p * 8 + i;
    if (i < 4) return h + 4 * q + i;
    return h + 16 + 4 * (q ^ 1) + (i - 4);
  endfunction

  logic [WW-1:0] w0 [NLANE];
  always_comb begin
    for (int l = 0; l < NLANE; l++) begin
      int r, c, xs;
      logic [AW-1:0] ea, a;
      r  = int'(in_row[l*RW +: RW]);
      c  = int'(in_col[l*CW +: CW]);
      xs = (r % NCOL) ^ c;
      ea = AW'(BASE_ADDR + 2 * (r * ROW_STRIDE + xs * KPACK));
      a  = in_swz ? ea : in_addr[l*AW +: AW];
      w0[l] = a[AW-1:2];
    end
  end

  logic [WW-1:0] s1_w [NLANE];
  logic          s1_v, s1_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_rd <= 1'b0;
      for (int l = 0; l < NLANE; l++) s1_w[l] <= '0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_rd <= in_read;
        for (int l = 0; l < NLANE; l++) s1_w[l] <= w0[l];
      end
    end
  end

  logic [DW-1:0] pdeg [NPH];
  always_comb begin
    for (int p = 0; p < NPH; p++) begin
      logic [WW-1:0] sw [NSLOT];
      logic          fst [NSLOT];
      int            best;
      for (int s = 0; s < NSLOT; s++)
        sw[s] = s1_w[lane_of(p, s / 4, s1_rd)] + WW'(s % 4);
      for (int s = 0; s < NSLOT; s++) begin
        fst[s] = 1'b1;
        for (int t = 0; t < s; t++)
          if (sw[t] == sw[s]) fst[s] = 1'b0;
      end
      best = 0;
      for (int b = 0; b < NBANK; b++) begin
        int cnt;
        cnt = 0;
        for (int s = 0; s < NSLOT; s++)
          if (fst[s] && sw[s][4:0] == 5'(b)) cnt++;
        if (cnt > best) best = cnt;
      end
      pdeg[p] = DW'(best);
    end
  end

  logic [DW-1:0] mx;
  logic          allfree;
  always_comb begin
    mx = '0;
    allfree = 1'b1;
    for (int p = 0; p < NPH; p++) begin
      if (pdeg[p] > mx) mx = pdeg[p];
      if (pdeg[p] > DW'(1)) allfree = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_phase_deg <= '0;
      out_max_deg   <= '0;
      out_conf_free <= 1'b0;
    end else begin
      out_valid <= s1_v;
      if (s1_v) begin
        for (int p = 0; p < NPH; p++) out_phase_deg[p*DW +: DW] <= pdeg[p];
        out_max_deg   <= mx;
        out_conf_free <= allfree;
      end
    end
  end

  // R6
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(!in_valid)) |=> ##1 !out_valid);
  // R5
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_conf_free == (out_max_deg <= 4'd1)));
  // R5
  max_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_max_deg >= 4'd1 && out_max_deg <= 4'd8));

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    // R4
    ph_deg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_phase_deg[g*DW +: DW] >= 4'd1 &&
                     out_phase_deg[g*DW +: DW] <= out_max_deg));
  end
endmodule

// File: tb/bank_conflict_chk_tb.sv
module bank_conflict_chk_tb_top;
  localparam int CLK_NS = 10;
  localparam int AW = 16, RW = 8;
  localparam int NREQ = 400;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n, in_valid, in_read, in_swz;
  logic [64*AW-1:0] in_addr;
  logic [64*RW-1:0] in_row;
  logic [64*3-1:0]  in_col;
  logic out_valid, out_conf_free;
  logic [31:0] out_phase_deg;
  logic [3:0]  out_max_deg;

  bank_conflict_chk dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_read(in_read),
    .in_swz(in_swz), .in_addr(in_addr), .in_row(in_row), .in_col(in_col),
    .out_valid(out_valid), .out_phase_deg(out_phase_deg),
    .out_max_deg(out_max_deg), .out_conf_free(out_conf_free));

  int checks = 0, errors = 0;
  int addr[64], row[64], col[64];
  bit rd, swz, vld;
  string tag;

  int    e_deg[4][8];
  int    e_max[4];
  bit    e_v[4];
  string e_tag[4];

  function automatic int eff_addr(int l);
    if (swz) return (2 * (row[l] * 64 + (((row[l] % 8) ^ col[l]) * 8))) & 16'hFFFF;
    return addr[l];
  endfunction

  function automatic int lane_at(int p, int i);
    int ra[4] = '{0, 4, 8, 12};
    int rb[4] = '{20, 16, 28, 24};
    if (!rd) return p * 8 + i;
    if (i < 4) return (p / 4) * 32 + ra[p % 4] + i;
    return (p / 4) * 32 + rb[p % 4] + i - 4;
  endfunction

  function automatic int phase_deg(int p);
    int w[32];
    int best = 0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 4; j++)
        w[i*4+j] = ((eff_addr(lane_at(p, i)) >> 2) + j) & 16'h3FFF;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int s = 0; s < 32; s++) begin
        bit dup = 0;
        for (int t = 0; t < s; t++) if (w[t] == w[s]) dup = 1;
        if (!dup && (w[s] % 32) == b) cnt++;
      end
      if (cnt > best) best = cnt;
    end
    return best;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_slot(int sl);
    chk("R6 out_valid", int'(out_valid), int'(e_v[sl]));
    if (e_v[sl] && out_valid) begin
      for (int p = 0; p < 8; p++)
        chk({e_tag[sl], " R4 phase degree"}, int'(out_phase_deg[p*4 +: 4]), e_deg[sl][p]);
      chk({e_tag[sl], " R5 max"}, int'(out_max_deg), e_max[sl]);
      chk({e_tag[sl], " R5 free"}, int'(out_conf_free), int'(e_max[sl] <= 1));
    end
  endtask

  task automatic gen(int k);
    for (int l = 0; l < 64; l++) begin
      addr[l] = $urandom & 16'hFFFF;
      row[l]  = $urandom % 256;
      col[l]  = $urandom % 8;
    end
    vld = 1; rd = 0; swz = 0; tag = "R2";
    case (k)
      0: for (int l = 0; l < 64; l++) addr[l] = l * 16;
      1: begin rd = 1; tag = "R3"; for (int l = 0; l < 64; l++) addr[l] = l * 16; end
      2: begin tag = "R4 same word"; for (int l = 0; l < 64; l++) addr[l] = 16'h0240; end
      3: begin tag = "R4 stride"; for (int l = 0; l < 64; l++) addr[l] = l * 128; end
      4: begin rd = 1; tag = "R3 stride"; for (int l = 0; l < 64; l++) addr[l] = l * 128; end
      5: begin tag = "R1 wrap"; for (int l = 0; l < 64; l++) addr[l] = l * 16 + 8; end
      6: begin tag = "R1 top"; for (int l = 0; l < 64; l++) addr[l] = 16'hFFF0 - (l % 2) * 4; end
      7: begin tag = "R2 grp"; for (int l = 0; l < 64; l++) addr[l] = (l % 4) * 16 + (l / 4) * 128; end
      8: begin rd = 1; tag = "R3 grp"; for (int l = 0; l < 64; l++) addr[l] = (l % 4) * 16 + (l / 4) * 128; end
      9: begin swz = 1; tag = "R7 swz"; for (int l = 0; l < 64; l++) begin row[l] = l; col[l] = 0; end end
      10: begin tag = "R7 noswz"; for (int l = 0; l < 64; l++) addr[l] = (l * 64) * 2; end
      11: begin swz = 1; rd = 1; tag = "R7 swz rd"; for (int l = 0; l < 64; l++) begin row[l] = l % 8 + 8 * (l / 32); col[l] = (l / 8) % 4; end end
      12: begin tag = "R4 mix"; for (int l = 0; l < 64; l++) addr[l] = (l % 2 == 0) ? 0 : 128 * (l % 8); end
      default: begin
        vld = ($urandom % 4) != 0;
        rd  = $urandom % 2;
        swz = ($urandom % 3) == 0;
        tag = swz ? "R7 rnd" : (rd ? "R3 rnd" : "R2 rnd");
        for (int l = 0; l < 64; l++)
          case ($urandom % 3)
            0: addr[l] = $urandom % 1024;
            1: addr[l] = ($urandom % 8) * 128 + ($urandom % 4) * 16;
            default: addr[l] = ($urandom % 64) * 16;
          endcase
      end
    endcase
  endtask

  task automatic apply();
    in_valid = vld; in_read = rd; in_swz = swz;
    for (int l = 0; l < 64; l++) begin
      in_addr[l*AW +: AW] = AW'(addr[l]);
      in_row[l*RW +: RW]  = RW'(row[l]);
      in_col[l*3 +: 3]    = 3'(col[l]);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; in_valid = 0; in_read = 0; in_swz = 0;
    in_addr = '0; in_row = '0; in_col = '0;
    for (int s = 0; s < 4; s++) e_v[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset valid", int'(out_valid), 0);
    chk("R8 reset degs", int'(out_phase_deg), 0);
    chk("R8 reset max", int'(out_max_deg), 0);
    chk("R8 reset free", int'(out_conf_free), 0);
    for (int k = 0; k < NREQ + 2; k++) begin
      @(negedge clk);
      if (k >= 2) check_slot((k + 2) % 4);
      if (k < NREQ) gen(k); else begin vld = 0; tag = "idle"; end
      apply();
      e_v[k % 4] = vld;
      e_tag[k % 4] = tag;
      if (vld) begin
        e_max[k % 4] = 0;
        for (int p = 0; p < 8; p++) begin
          e_deg[k % 4][p] = phase_deg(p);
          if (e_deg[k % 4][p] > e_max[k % 4]) e_max[k % 4] = e_deg[k % 4][p];
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule